// File: doc/BRIEF.md
# Locked Indexed Chipset Configuration Port

This block is a chipset configuration space that the processor reaches through two I/O ports. One port selects a byte register by number and the other port reads or writes the selected register. A file of 256 byte registers sits behind the pair. The file is write-protected after reset. Software must write a key byte to the lock register before any other write takes effect. A non-key byte written to the lock register closes the file again.

Three of the registers drive the memory controller. One register holds a per-segment enable for the eight 32 KB segments of the upper memory area, which runs from 0xC0000 to 0xFFFFF. A second register holds a global pair of bits that steers reads and writes of the enabled segments to on-board DRAM. Segments that are not enabled always go to the external bus. A third register carries the external-cache enable. The routing outputs are registered. A memory decoder may use them directly, and they change one cycle after a write that reaches their source registers.

Top module: `chipset_cfg_port`

## Requirements
- R1: A write cycle to I/O address 0x22 loads the written byte into the index register. Later data-port accesses use that index.
- R2: After reset the file is locked, all 256 registers hold 0x00, and every routing and cache output is 0.
- R3: While the file is locked, a data-port write (I/O address 0x23) leaves every register unchanged, unless it is the unlock write described in R4.
- R4: A data-port write of 0xC5 while the index is 0x03 unlocks the file and stores 0xC5 in register 0x03.
- R5: A data-port write of any value other than 0xC5 while the index is 0x03 locks the file, and register 0x03 keeps its previous contents.
- R6: While the file is unlocked, a data-port write at any index other than 0x03 stores the full byte in the register at that index.
- R7: Segment i (base 0xC0000 + i*0x8000, i = 0..7) has read-internal output bit i equal to register 0x13 bit i AND register 0x14 bit 0.
- R8: Segment i has write-internal output bit i equal to register 0x13 bit i AND register 0x14 bit 1.
- R9: The BIOS shadow-read output is register 0x13 bit 6 AND register 0x14 bit 0. The BIOS shadow-write output is register 0x13 bit 6 AND register 0x14 bit 1.
- R10: The external-cache enable output equals register 0x18 bit 1.
- R11: A read cycle at I/O address 0x23 returns the register at the current index whether the file is locked or not. Any other read, and any cycle without a read, returns 0xFF.
- R12: The outputs of R7 to R10 are registered. They keep their old value in the clock cycle after the edge that accepts a write, and they show the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| seg_rd_int | output | 8 | Per-segment read-to-DRAM routing |
| seg_wr_int | output | 8 | Per-segment write-to-DRAM routing |
| bios_shadow_rd | output | 1 | BIOS segment shadow read active |
| bios_shadow_wr | output | 1 | BIOS segment shadow write active |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The hardest state to reach from the ports is a change of lock state in the middle of a sequence. A typical case is a key write that is followed by a non-key write to the lock register and then by writes to the routing registers, which the block must drop. Uniform random values almost never produce the key at index 0x03. The stimulus therefore biases index writes toward 0x03, 0x13, 0x14 and 0x18, and it writes the key in about a quarter of data writes. This makes the block pass between the locked and unlocked states many times during the run. Directed cases cover the one-cycle routing delay and the retained value of register 0x03 after a relock.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    // I/O decode constants and register numbers shared by the block
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam logic [15:0] PORT_INDEX = 16'h0022;
    localparam logic [15:0] PORT_DATA  = 16'h0023;
    localparam logic [7:0]  IDX_LOCK   = 8'h03;
    localparam logic [7:0]  LOCK_KEY   = 8'hC5;
    localparam logic [7:0]  IDX_SEGEN  = 8'h13;
    localparam logic [7:0]  IDX_ROUTE  = 8'h14;
    localparam logic [7:0]  IDX_CACHE  = 8'h18;
    localparam int unsigned NSEG       = 8;
    localparam int unsigned BIOS_SEG   = 6;

    typedef enum logic { LK_CLOSED = 1'b0, LK_OPEN = 1'b1 } lock_state_t;
endpackage

// File: rtl/cfgp_io_decode.sv
// cfgp_io_decode: turns raw I/O strobes into index-write, data-write and
// data-read enables. Assumes one strobe per access cycle; no state.
module cfgp_io_decode #(
    parameter int unsigned          AW     = cfgp_pkg::ADDR_W,
    parameter logic [AW-1:0]        P_INDEX = cfgp_pkg::PORT_INDEX,
    parameter logic [AW-1:0]        P_DATA  = cfgp_pkg::PORT_DATA
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    output logic          idx_we,
    output logic          dat_we,
    output logic          dat_re
);
    // Address compare for the two ports
    always_comb begin
        idx_we = io_wr && (io_addr == P_INDEX);
        dat_we = io_wr && (io_addr == P_DATA);
        dat_re = io_rd && (io_addr == P_DATA);
    end
endmodule

// File: rtl/cfgp_lock_ctl.sv
// cfgp_lock_ctl: lock state machine. Any data write at the lock index
// decides the new state (key opens, anything else closes); the write
// enable for the register file is granted from the state the write sees.
module cfgp_lock_ctl #(
    parameter int unsigned     DW   = cfgp_pkg::DATA_W,
    parameter logic [DW-1:0]   LIDX = cfgp_pkg::IDX_LOCK,
    parameter logic [DW-1:0]   KEY  = cfgp_pkg::LOCK_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_we,
    input  logic [DW-1:0] index,
    input  logic [DW-1:0] wdata,
    output logic          locked,
    output logic          reg_we
);
    import cfgp_pkg::*;

    lock_state_t state_q, state_d;
    logic        at_lock, is_key;

    // Classify the current data write
    always_comb begin
        at_lock = (index == LIDX);
        is_key  = (wdata == KEY);
    end

    // Next state and register-file grant
    always_comb begin
        state_d = state_q;
        reg_we  = 1'b0;
        if (dat_we) begin
            if (at_lock) begin
                state_d = is_key ? LK_OPEN : LK_CLOSED;
                reg_we  = is_key;
            end else begin
                reg_we  = (state_q == LK_OPEN);
            end
        end
    end

    // State register, closed after reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    assign locked = (state_q == LK_CLOSED);
endmodule

// File: rtl/cfgp_regfile.sv
// cfgp_regfile: byte register file with one write port, one indexed read
// port and fixed taps for the registers that drive hardware. All entries
// clear on reset.
module cfgp_regfile #(
    parameter int unsigned   DW    = cfgp_pkg::DATA_W,
    parameter logic [DW-1:0] T_SEG = cfgp_pkg::IDX_SEGEN,
    parameter logic [DW-1:0] T_RTE = cfgp_pkg::IDX_ROUTE,
    parameter logic [DW-1:0] T_CCH = cfgp_pkg::IDX_CACHE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] tap_seg,
    output logic [DW-1:0] tap_rte,
    output logic [DW-1:0] tap_cch
);
    localparam int unsigned NREG = 1 << DW;

    logic [DW-1:0] mem [NREG];

    // Storage: clear on reset, single write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Indexed read and hardware taps
    always_comb begin
        rdata   = mem[addr];
        tap_seg = mem[T_SEG];
        tap_rte = mem[T_RTE];
        tap_cch = mem[T_CCH];
    end
endmodule

// File: rtl/cfgp_shadow_map.sv
// cfgp_shadow_map: registers the per-segment routing, the BIOS shadow
// pair and the cache enable from the tapped registers. Assumes bit 0 of
// the route register is the read select and bit 1 the write select.
module cfgp_shadow_map #(
    parameter int unsigned DW    = cfgp_pkg::DATA_W,
    parameter int unsigned NS    = cfgp_pkg::NSEG,
    parameter int unsigned BSEG  = cfgp_pkg::BIOS_SEG,
    parameter int unsigned CBIT  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] seg_en,
    input  logic [DW-1:0] route,
    input  logic [DW-1:0] cache_reg,
    output logic [NS-1:0] seg_rd_int,
    output logic [NS-1:0] seg_wr_int,
    output logic          bios_rd,
    output logic          bios_wr,
    output logic          cache_en
);
    genvar g;
    generate
        for (g = 0; g < NS; g++) begin : g_seg
            // Per-segment routing flops
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seg_rd_int[g] <= 1'b0;
                    seg_wr_int[g] <= 1'b0;
                end else begin
                    seg_rd_int[g] <= seg_en[g] & route[0];
                    seg_wr_int[g] <= seg_en[g] & route[1];
                end
            end
        end
    endgenerate

    // BIOS pair and cache enable flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bios_rd  <= 1'b0;
            bios_wr  <= 1'b0;
            cache_en <= 1'b0;
        end else begin
            bios_rd  <= seg_en[BSEG] & route[0];
            bios_wr  <= seg_en[BSEG] & route[1];
            cache_en <= cache_reg[CBIT];
        end
    end
endmodule

// File: rtl/chipset_cfg_port.sv
// chipset_cfg_port: indexed configuration port with key lock, register file
// and registered shadow routing. Assumes single-cycle I/O strobes and a
// synchronous active-low reset.
module chipset_cfg_port #(
    parameter int unsigned AW = cfgp_pkg::ADDR_W,
    parameter int unsigned DW = cfgp_pkg::DATA_W,
    parameter int unsigned NS = cfgp_pkg::NSEG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic [NS-1:0] seg_rd_int,
    output logic [NS-1:0] seg_wr_int,
    output logic          bios_shadow_rd,
    output logic          bios_shadow_wr,
    output logic          ext_cache_en
);
    logic          idx_we, dat_we, dat_re;
    logic          locked, reg_we;
    logic [DW-1:0] idx_q, cur_val, r_seg, r_rte, r_cch;

    cfgp_io_decode #(.AW(AW)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .idx_we  (idx_we),
        .dat_we  (dat_we),
        .dat_re  (dat_re)
    );

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= io_wdata;
    end

    cfgp_lock_ctl #(.DW(DW)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .dat_we (dat_we),
        .index  (idx_q),
        .wdata  (io_wdata),
        .locked (locked),
        .reg_we (reg_we)
    );

    cfgp_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (idx_q),
        .wdata   (io_wdata),
        .rdata   (cur_val),
        .tap_seg (r_seg),
        .tap_rte (r_rte),
        .tap_cch (r_cch)
    );

    cfgp_shadow_map #(.DW(DW), .NS(NS)) u_shd (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_en     (r_seg),
        .route      (r_rte),
        .cache_reg  (r_cch),
        .seg_rd_int (seg_rd_int),
        .seg_wr_int (seg_wr_int),
        .bios_rd    (bios_shadow_rd),
        .bios_wr    (bios_shadow_wr),
        .cache_en   (ext_cache_en)
    );

    // Read data: selected register on a data-port read, all ones otherwise
    assign io_rdata = dat_re ? cur_val : '1;
endmodule

// File: rtl/cfgp_checker.sv
// cfgp_checker: protocol properties of the configuration port, bound to
// the top module.
module cfgp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dat_we,
    input logic [7:0] idx_q,
    input logic [7:0] io_wdata,
    input logic       locked,
    input logic [7:0] cur_val,
    input logic [7:0] r_seg,
    input logic [7:0] r_rte,
    input logic [7:0] r_cch,
    input logic [7:0] seg_rd_int,
    input logic [7:0] seg_wr_int,
    input logic       bios_shadow_rd,
    input logic       bios_shadow_wr,
    input logic       ext_cache_en
);
    a_r3_locked_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && locked && idx_q != 8'h03) |=> $stable(cur_val));

    a_r4_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == 8'h03 && io_wdata == 8'hC5) |=> (!locked && cur_val == 8'hC5));

    a_r5_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == 8'h03 && io_wdata != 8'hC5) |=> (locked && $stable(cur_val)));

    a_r6_open_store: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !locked && idx_q != 8'h03) |=> (cur_val == $past(io_wdata)));

    a_r7_seg_read: assert property (@(posedge clk) disable iff (!rst_n)
        seg_rd_int == ($past(r_seg) & {8{$past(r_rte[0])}}));

    a_r8_seg_write: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_int == ($past(r_seg) & {8{$past(r_rte[1])}}));

    a_r9_bios_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bios_shadow_rd == seg_rd_int[6]) && (bios_shadow_wr == seg_wr_int[6]));

    a_r10_cache: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cache_en == $past(r_cch[1]));
endmodule

bind chipset_cfg_port cfgp_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dat_we         (dat_we),
    .idx_q          (idx_q),
    .io_wdata       (io_wdata),
    .locked         (locked),
    .cur_val        (cur_val),
    .r_seg          (r_seg),
    .r_rte          (r_rte),
    .r_cch          (r_cch),
    .seg_rd_int     (seg_rd_int),
    .seg_wr_int     (seg_wr_int),
    .bios_shadow_rd (bios_shadow_rd),
    .bios_shadow_wr (bios_shadow_wr),
    .ext_cache_en   (ext_cache_en)
);

// File: tb/chipset_cfg_port_bench.sv
`timescale 1ns/1ps
module chipset_cfg_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [7:0]  seg_rd_int, seg_wr_int;
    logic        bios_shadow_rd, bios_shadow_wr, ext_cache_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_reg [256];
    logic [7:0] m_idx;
    bit         m_open;

    always #2.5 clk = ~clk;

    chipset_cfg_port u_chipset_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
        .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr),
        .ext_cache_en(ext_cache_en)
    );

    function automatic logic [7:0] f_seg(input logic [7:0] en, input logic sel);
        return en & {8{sel}};
    endfunction

    function automatic logic [11:0] f_outs();
        logic [7:0] e, r;
        e = m_reg[8'h13];
        r = m_reg[8'h14];
        return {e[6] & r[0], e[6] & r[1], m_reg[8'h18][1], 1'b0,
                8'h0} | {4'h0, 8'h0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " R7"},  {24'h0, seg_rd_int}, {24'h0, f_seg(m_reg[8'h13], m_reg[8'h14][0])});
        chk({tag, " R8"},  {24'h0, seg_wr_int}, {24'h0, f_seg(m_reg[8'h13], m_reg[8'h14][1])});
        chk({tag, " R9"},  {30'h0, bios_shadow_rd, bios_shadow_wr}, {29'h0, f_outs() >> 9} >> 1);
        chk({tag, " R10"}, {31'h0, ext_cache_en}, {31'h0, m_reg[8'h18][1]});
    endtask

    // one write cycle; model updates as the clock edge commits it
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        if (a == 16'h22) m_idx = d;
        else if (a == 16'h23) begin
            if (m_idx == 8'h03) begin
                m_open = (d == 8'hC5);
                if (m_open) m_reg[8'h03] = d;
            end else if (m_open) m_reg[m_idx] = d;
        end
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input bit rd, input string req);
        logic [7:0] exp;
        io_addr = a; io_rd = rd;
        #0.5;
        exp = (rd && a == 16'h23) ? m_reg[m_idx] : 8'hFF;
        chk(req, {24'h0, io_rdata}, {24'h0, exp});
        io_rd = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] pick [4] = '{8'h03, 8'h13, 8'h14, 8'h18};
        void'($urandom(32'h0C5A_1429));
        for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
        m_idx = 8'h00; m_open = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk_outs("R2");
        io_write(16'h22, 8'h13);
        io_read(16'h23, 1'b1, "R2 reg13 clear");
        // R3 locked write discarded
        io_write(16'h23, 8'hFF);
        io_read(16'h23, 1'b1, "R3 locked discard");
        settle(); chk_outs("R3");
        // R4 unlock with key
        io_write(16'h22, 8'h03);
        io_write(16'h23, 8'hC5);
        io_read(16'h23, 1'b1, "R4 key stored");
        // R6 + R12: write reg13 then check old outputs one cycle, new next
        io_write(16'h22, 8'h14);
        io_write(16'h23, 8'h03);
        settle();
        io_write(16'h22, 8'h13);
        @(negedge clk); io_addr = 16'h23; io_wdata = 8'hA5; io_wr = 1'b1;
        @(posedge clk); m_reg[8'h13] = 8'hA5;
        @(negedge clk); io_wr = 1'b0;
        chk("R12 old value held", {24'h0, seg_rd_int}, 32'h0);
        settle(); chk_outs("R12 new");
        // R5 relock keeps reg03
        io_write(16'h22, 8'h03);
        io_write(16'h23, 8'h5A);
        io_read(16'h23, 1'b1, "R5 reg03 kept");
        io_write(16'h22, 8'h13);
        io_write(16'h23, 8'h00);
        io_read(16'h23, 1'b1, "R5 relocked discard");
        settle(); chk_outs("R5");
        // R11 other port and idle reads
        io_read(16'h22, 1'b1, "R11 other port");
        io_read(16'h23, 1'b0, "R11 no strobe");
        // R1 index then random mix
        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            op = $urandom % 8;
            if (op < 2) begin
                v = ($urandom % 3 != 0) ? pick[$urandom % 4] : 8'($urandom);
                io_write(16'h22, v);
                io_read(16'h23, 1'b1, "R1 index select");
            end else if (op < 5) begin
                v = ($urandom % 4 == 0) ? 8'hC5 : 8'($urandom);
                io_write(16'h23, v);
                io_read(16'h23, 1'b1, "R6 readback");
            end else if (op == 5) begin
                io_read(16'($urandom % 64), 1'b1, "R11 random port");
            end else begin
                io_read(16'h23, 1'b1, "R11 data read");
            end
            settle();
            chk_outs("rand");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule